// File: doc/BRIEF.md
# Edge-Selectable Auto-Reload Event Counter

This block counts transitions on an external event pin with a 16-bit down-counter that runs on the system clock. It does not count clock cycles. The pin is brought into the clock domain by a two-flop synchronizer, and a control bit picks whether rising or falling transitions are counted. When an event arrives while the counter is already zero, the counter underflows. It then reloads from an auto-reload register and sets a sticky pending flag. An interrupt output follows the pending flag, gated by a local enable bit and by a chip-level global enable input.

The host reaches the block through a small register port: a write strobe, a 2-bit address and 16-bit write data, plus a combinational read-data bus that follows the address. To count N events and be flagged on the Nth, the host preloads N-1 into both the counter and the reload register. To count freely, it loads 0xFFFF into both.

Top module: `evtcnt_top`

## Requirements
- R1: Each qualifying event transition decrements the 16-bit counter by exactly one. Clock cycles without an event leave the counter unchanged.
- R2: Control bit 1 selects the counted transition: 0 counts rising transitions and 1 counts falling transitions. A transition of the other polarity has no effect on the counter.
- R3: The event input passes through two synchronizer flops and one history flop. A level change driven between clock edges alters the counter on the third rising clock edge after it, and not before. A pulse held for one clock period is counted once. At most one decrement happens per clock.
- R4: An event that finds the counter at a nonzero value, including 1, never sets the pending flag. Only the next event after the counter reaches zero causes underflow, so a preload of N-1 raises the flag on the Nth event.
- R5: On underflow the counter takes the value held in the reload register (address 1) and counts down from it.
- R6: Every underflow sets the pending flag, which is read at control bit 3. The flag stays set until the host writes the control register (address 2) with bit 3 equal to 1. When such a clear and an underflow fall in the same cycle, the flag stays set.
- R7: `irq` is 1 exactly when the pending flag, control bit 2 (local interrupt enable) and `globalIntEn` are all 1.
- R8: While control bit 0 (run) is 0, event transitions change neither the counter nor the pending flag.
- R9: With 0xFFFF in the reload register, an underflow from zero yields 0xFFFF, and the next event yields 0xFFFE.
- R10: A write to address 0 loads the counter on the next clock edge. If an event arrives in the same cycle, the write wins: the event is dropped and the pending flag is not set.
- R11: Reads return the counter at address 0 and the reload register at address 1. At address 2 they return the control bits in [2:0] and the pending flag in bit 3, with all upper bits 0. Address 3 reads 0. After reset, all registers, the pending flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 1 | External event input, asynchronous to clk |
| globalIntEn | input | 1 | Chip-level interrupt enable |
| regWrEn | input | 1 | Host write strobe |
| regAddr | input | 2 | Register address for both writes and reads |
| regWrData | input | 16 | Host write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are two collisions: a host write and a synchronized event landing on the same clock edge, once with a write to the counter and once with a pending-clear. The event only takes effect three clock edges after the pin changes. The stimulus therefore flips the event pin on a falling clock edge, lets exactly two more falling edges pass, and only then raises the write strobe, so that the write and the edge-detect strobe share one rising edge. The same cycle counting also checks, from the pins alone, that the counter has not yet moved after two edges and has moved after the third.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  // control register bit positions
  localparam int BIT_RUN   = 0;
  localparam int BIT_FALL  = 1;
  localparam int BIT_INTEN = 2;
  localparam int BIT_PEND  = 3;

  typedef struct packed {
    logic intEn;
    logic edgeFall;
    logic runEn;
  } ctrl_t;

  typedef struct packed {
    logic wrCount;
    logic wrReload;
    logic clrPend;
    logic evtHit;
  } strobe_t;

endpackage

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evtIn,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CNT_W-1:0]    regWrData,
  output strobe_t             strb,
  output ctrl_t               ctrlQ
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   histQ;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   ctrlWr;

  // synchronizer chain, first stage takes the raw pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      histQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], evtIn};
      histQ <= syncOut;
    end
  end

  assign syncOut  = syncQ[SYNC_STAGES-1];
  assign riseSeen = syncOut & ~histQ;
  assign fallSeen = ~syncOut & histQ;

  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ.runEn    <= regWrData[BIT_RUN];
      ctrlQ.edgeFall <= regWrData[BIT_FALL];
      ctrlQ.intEn    <= regWrData[BIT_INTEN];
    end
  end

  always_comb begin
    strb.wrCount  = regWrEn && (regAddr == ADDR_COUNT);
    strb.wrReload = regWrEn && (regAddr == ADDR_RELOAD);
    strb.clrPend  = ctrlWr && regWrData[BIT_PEND];
    strb.evtHit   = ctrlQ.runEn && (ctrlQ.edgeFall ? fallSeen : riseSeen);
  end

  // same-polarity edges need the synchronized level to toggle twice
  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    strb.evtHit |=> !strb.evtHit); // R3

endmodule

// File: rtl/evtcnt_datapath.sv
module evtcnt_datapath
  import evtcnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  ctrl_t               ctrlQ,
  input  logic [CNT_W-1:0]    wrData,
  input  logic                globalIntEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [CNT_W-1:0]    rdData,
  output logic                irq
);

  localparam int CTRL_USED = BIT_PEND + 1;

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] reloadQ;
  logic             pendQ;
  logic             atZero;
  logic             underflow;

  assign atZero    = (cntQ == '0);
  assign underflow = strb.evtHit && !strb.wrCount && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.wrCount) begin
      cntQ <= wrData;
    end else if (strb.evtHit) begin
      cntQ <= atZero ? reloadQ : cntQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strb.wrReload) begin
      reloadQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (underflow) begin
      pendQ <= 1'b1;
    end else if (strb.clrPend) begin
      pendQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_COUNT:  rdData = cntQ;
      ADDR_RELOAD: rdData = reloadQ;
      ADDR_CTRL: begin
        rdData[BIT_RUN]   = ctrlQ.runEn;
        rdData[BIT_FALL]  = ctrlQ.edgeFall;
        rdData[BIT_INTEN] = ctrlQ.intEn;
        rdData[BIT_PEND]  = pendQ;
        rdData[CNT_W-1:CTRL_USED] = '0;
      end
      default: rdData = '0;
    endcase
  end

  assign irq = pendQ && ctrlQ.intEn && globalIntEn;

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtHit && !strb.wrCount && cntQ != '0) |=> (cntQ == $past(cntQ) - 1'b1)); // R1

  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtHit && !strb.wrCount && cntQ == '0) |=> (cntQ == $past(reloadQ) && pendQ)); // R5

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !strb.clrPend) |=> pendQ); // R6

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.evtHit && !strb.wrCount) |=> $stable(cntQ)); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCount && !pendQ && !strb.clrPend) |=> (cntQ == $past(wrData) && !pendQ)); // R10

endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
  import evtcnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtIn,
  input  logic              globalIntEn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              irq
);

  strobe_t strb;
  ctrl_t   ctrlQ;

  evtcnt_ctrl #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb),
    .ctrlQ     (ctrlQ)
  );

  evtcnt_datapath #(
    .CNT_W (CNT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ctrlQ       (ctrlQ),
    .wrData      (regWrData),
    .globalIntEn (globalIntEn),
    .rdAddr      (regAddr),
    .rdData      (regRdData),
    .irq         (irq)
  );

endmodule

// File: tb/evtcnt_top_tb_top.sv
`timescale 1ns/1ps
module evtcnt_top_tb_top;

  typedef struct {
    int          kind;   // 0 = register read, 1 = irq level
    logic [1:0]  addr;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtIn = 1'b0;
  logic        globalIntEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  drvAddr = 2'd0;
  logic [1:0]  monAddr = 2'd0;
  logic        monActive = 1'b0;
  logic [1:0]  regAddr;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        irq;

  int total = 0;
  int failed = 0;
  item_t expQ[$];

  always #5 clk = ~clk;

  assign regAddr = monActive ? monAddr : drvAddr;

  evtcnt_top dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .evtIn       (evtIn),
    .globalIntEn (globalIntEn),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .irq         (irq)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    item_t it;
    forever begin
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      monActive = 1'b1;
      monAddr = it.addr;
      #1;
      total++;
      if (it.kind == 1) begin
        if (irq !== it.exp[0]) begin
          failed++;
          $display("FAIL %s irq actual=%0b expected=%0b", it.tag, irq, it.exp[0]);
        end
      end else if (regRdData !== it.exp) begin
        failed++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, regRdData, it.exp);
      end
      monActive = 1'b0;
    end
  end

  task automatic expectReg(input logic [1:0] a, input logic [15:0] v, input string tag);
    item_t it;
    it.kind = 0; it.addr = a; it.exp = v; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    #2;
  endtask

  task automatic expectIrq(input logic v, input string tag);
    item_t it;
    it.kind = 1; it.addr = 2'd0; it.exp = {15'd0, v}; it.tag = tag;
    expQ.push_back(it);
    wait (expQ.size() == 0);
    #2;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk);
    regWrEn = 1'b1; drvAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // full rising+falling pulse, each level held two clocks
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evtIn = 1'b1;
      @(negedge clk);
      @(negedge clk); evtIn = 1'b0;
      @(negedge clk);
    end
    settle();
  endtask

  // rising event timed to meet a host write on the same clock edge
  task automatic riseWithWrite(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    regWrEn = 1'b1; drvAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    settle();
    evtIn = 1'b0;
    settle();
  endtask

  initial begin
    #1_000_000;
    failed++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state and map
    expectReg(2'd0, 16'h0000, "R11 reset counter");
    expectReg(2'd1, 16'h0000, "R11 reset reload");
    expectReg(2'd2, 16'h0000, "R11 reset control");
    expectIrq(1'b0, "R11 reset irq");
    writeReg(2'd1, 16'd3);
    writeReg(2'd0, 16'd3);
    expectReg(2'd0, 16'd3, "R11 counter readback");
    expectReg(2'd1, 16'd3, "R11 reload readback");
    expectReg(2'd3, 16'h0000, "R11 unused address");

    // R8 stopped counter ignores events
    pulses(2);
    expectReg(2'd0, 16'd3, "R8 stopped ignores events");

    // R3 latency, rising mode
    writeReg(2'd2, 16'h0001);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectReg(2'd0, 16'd3, "R3 no change after two edges");
    @(negedge clk);
    expectReg(2'd0, 16'd2, "R3 change on third edge");
    settle();
    evtIn = 1'b0;
    settle();
    expectReg(2'd0, 16'd2, "R2 falling ignored in rising mode");

    // R1 / R4 / R5
    pulses(2);
    expectReg(2'd0, 16'd0, "R1 decremented to zero");
    expectReg(2'd2, 16'h0001, "R4 zero does not set pending");
    pulses(1);
    expectReg(2'd0, 16'd3, "R5 reloaded on underflow");
    expectReg(2'd2, 16'h0009, "R6 pending set");

    // R7 interrupt gating
    expectIrq(1'b0, "R7 irq masked by local enable");
    writeReg(2'd2, 16'h0005);
    expectIrq(1'b0, "R7 irq masked by global enable");
    @(negedge clk); globalIntEn = 1'b1;
    expectIrq(1'b1, "R7 irq asserted");
    writeReg(2'd2, 16'h000D);
    expectReg(2'd2, 16'h0005, "R6 pending cleared by host");
    expectIrq(1'b0, "R7 irq drops with pending");

    // R2 falling mode
    writeReg(2'd2, 16'h0003);
    @(negedge clk); evtIn = 1'b1;
    settle();
    expectReg(2'd0, 16'd3, "R2 rising ignored in falling mode");
    evtIn = 1'b0;
    settle();
    expectReg(2'd0, 16'd2, "R2 falling counted");

    // R3 single-cycle pulse, rising mode
    writeReg(2'd2, 16'h0001);
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); evtIn = 1'b0;
    settle();
    expectReg(2'd0, 16'd1, "R3 one-cycle pulse counted once");

    // R4 N-1 preload, N = 5
    writeReg(2'd1, 16'd4);
    writeReg(2'd0, 16'd4);
    pulses(4);
    expectReg(2'd2, 16'h0001, "R4 no flag after N-1 events");
    pulses(1);
    expectReg(2'd2, 16'h0009, "R4 flag on Nth event");
    pulses(3);
    expectReg(2'd2, 16'h0009, "R6 pending stays set");

    // R6 clear colliding with underflow
    writeReg(2'd0, 16'd0);
    riseWithWrite(2'd2, 16'h0009);
    expectReg(2'd2, 16'h0009, "R6 underflow beats clear");
    expectReg(2'd0, 16'd4, "R5 reload on collision");

    // R10 counter write colliding with event
    writeReg(2'd2, 16'h0009);
    writeReg(2'd0, 16'd0);
    riseWithWrite(2'd0, 16'h1234);
    expectReg(2'd0, 16'h1234, "R10 write beats event");
    expectReg(2'd2, 16'h0001, "R10 no pending from dropped event");

    // R9 free-running wrap
    writeReg(2'd1, 16'hFFFF);
    writeReg(2'd0, 16'd1);
    pulses(2);
    expectReg(2'd0, 16'hFFFF, "R9 wraps to FFFF");
    pulses(1);
    expectReg(2'd0, 16'hFFFE, "R9 continues from FFFF");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule